// File: doc/BRIEF.md
# TDM Playback Sample Receiver

This block deserialises a time-division multiplexed audio stream carried on one data line. A frame-sync line marks each frame and a bit clock times each bit. From every frame the block extracts a single playback sample and presents it as a sign-extended 32-bit word, with a one-cycle strobe, in the bit-clock domain. The sample is either a mono pick or a stereo down-mix of two slots.

The framing is set by static configuration inputs:
- the frame-sync edge that opens a frame;
- the bit-clock edge on which the lines are captured;
- the delay from frame start to slot 0;
- the slot width;
- the sample word width;
- the placement of the word inside its slot.

The playback source is one of four choices: the slot named by an address-derived index, the left slot, the right slot, or their average. A slot whose last bit does not arrive before the next frame starts counts as missing and contributes zero. The sample of a frame is delivered when the following frame begins.

Top module: `tdm_playback_rx`

## Requirements
- R1: With `fs_fall_start` = 0 a frame opens when the captured frame sync goes from 0 to 1. With 1 it opens when it goes from 1 to 0.
- R2: With `cap_on_fall` = 0 both `fsync` and `sdin` are captured on the rising edge of `bclk`. With 1 they are captured on the falling edge. In both cases the results appear after the next rising edge.
- R3: Slot 0 begins `slot0_delay` bit periods after the bit captured together with the frame-start transition. That bit is bit index 0 of the frame, so a delay of 0 puts the most significant bit of slot 0 on it.
- R4: `slot_len_sel` sets the slot width: 0 = 16 bits, 1 = 24 bits, 2 = 32 bits, 3 = treated as 32 bits. Slots follow each other back to back, and each slot is sent most significant bit first.
- R5: `word_len_sel` sets the word width: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. If the word width exceeds the slot width, it is cut to the slot width. With `right_just` = 0 the word is the top bits of the slot. The word is delivered on `sample` sign-extended to 32 bits.
- R6: With `right_just` = 1 the word is the bottom bits of the slot.
- R7: `src_sel` = 0 plays the slot `addr_slot`. `src_sel` = 1 plays `left_slot` and `src_sel` = 2 plays `right_slot`.
- R8: `src_sel` = 3 delivers floor((L + R) / 2). L and R are the sign-extended words of `left_slot` and `right_slot`, and the sum is formed without overflow.
- R9: A chosen slot whose last bit lies past the end of its frame (offset + (slot+1) x width > frame length in bits) contributes zero. In mono modes the delivered sample is then zero.
- R10: Each frame start after the first one since reset raises `sample_vld` for exactly one cycle, carrying the sample of the frame just ended. The first frame start after reset delivers nothing.
- R11: During and right after reset `sample_vld` is 0 and `sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync line |
| sdin | input | 1 | Serial audio data line |
| fs_fall_start | input | 1 | 0: frame opens on rising sync, 1: on falling sync |
| cap_on_fall | input | 1 | 0: capture on rising bclk, 1: on falling bclk |
| slot0_delay | input | OFF_W (5) | Bit periods from frame start to slot 0 |
| slot_len_sel | input | 2 | Slot width code |
| word_len_sel | input | 2 | Word width code |
| right_just | input | 1 | 0: word at slot top, 1: word at slot bottom |
| src_sel | input | 2 | Playback source code |
| left_slot | input | SLOT_W (4) | Left slot index |
| right_slot | input | SLOT_W (4) | Right slot index |
| addr_slot | input | SLOT_W (4) | Slot index derived from the device address |
| sample | output | 32 | Sign-extended playback sample |
| sample_vld | output | 1 | One-cycle strobe for `sample` |

## Verification
The assertions assume that the configuration inputs are held constant between resets. They also assume that every frame lasts at least two bit periods, so frame starts can never come in consecutive cycles. The stimulus respects both: it changes the configuration only while reset is held, and it builds each frame with the sync line at one level for the first half and the other level for the second half. The length of every frame is 64 bits or more. Data and sync change one nanosecond after a rising edge, which keeps them stable at both capture edges.

// File: rtl/tdm_playback_rx.sv
module tdm_playback_rx #(
  parameter int OFF_W     = 5,
  parameter int SLOT_W    = 4,
  parameter int SLOTCNT_W = 6
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sdin,
  input  logic              fs_fall_start,
  input  logic              cap_on_fall,
  input  logic [OFF_W-1:0]  slot0_delay,
  input  logic [1:0]        slot_len_sel,
  input  logic [1:0]        word_len_sel,
  input  logic              right_just,
  input  logic [1:0]        src_sel,
  input  logic [SLOT_W-1:0] left_slot,
  input  logic [SLOT_W-1:0] right_slot,
  input  logic [SLOT_W-1:0] addr_slot,
  output logic [31:0]       sample,
  output logic              sample_vld
);

  localparam int PAD_W = SLOTCNT_W - SLOT_W;

  logic fs_n, sd_n;
  always_ff @(negedge bclk or negedge rst_n)
    if (!rst_n) begin
      fs_n <= 1'b0;
      sd_n <= 1'b0;
    end else begin
      fs_n <= fsync;
      sd_n <= sdin;
    end

  logic fs_c, sd_c, fs_q, frame_go;
  assign fs_c = cap_on_fall ? fs_n : fsync;
  assign sd_c = cap_on_fall ? sd_n : sdin;
  assign frame_go = fs_fall_start ? (fs_q & ~fs_c) : (~fs_q & fs_c);

  logic [5:0] slen_n, wlen_n, weff;
  always_comb begin
    case (slot_len_sel)
      2'd0:    slen_n = 6'd16;
      2'd1:    slen_n = 6'd24;
      default: slen_n = 6'd32;
    endcase
    case (word_len_sel)
      2'd0:    wlen_n = 6'd16;
      2'd1:    wlen_n = 6'd20;
      2'd2:    wlen_n = 6'd24;
      default: wlen_n = 6'd32;
    endcase
    weff = (wlen_n < slen_n) ? wlen_n : slen_n;
  end

  logic [OFF_W:0]     lead_q, cur_lead;
  logic               in_q, in_eff, active, enter, last_bit, seen_q;
  logic [4:0]         bit_q, cur_bit;
  logic [SLOTCNT_W-1:0] slot_q, cur_slot;

  assign cur_lead = frame_go ? '0 : lead_q;
  assign in_eff   = in_q & ~frame_go;
  assign active   = in_eff | (cur_lead == {1'b0, slot0_delay});
  assign enter    = active & ~in_eff;
  assign cur_bit  = enter ? '0 : bit_q;
  assign cur_slot = enter ? '0 : slot_q;
  assign last_bit = ({1'b0, cur_bit} == slen_n - 6'd1);

  logic [SLOT_W-1:0] slot_a;
  assign slot_a = (src_sel == 2'd0) ? addr_slot :
                  (src_sel == 2'd2) ? right_slot : left_slot;

  logic hit_a, hit_b;
  assign hit_a = active && (cur_slot == {{PAD_W{1'b0}}, slot_a});
  assign hit_b = active && (cur_slot == {{PAD_W{1'b0}}, right_slot});

  logic [31:0] sh_a, sh_b, base_a, base_b;
  logic        done_a, done_b;
  assign base_a = frame_go ? '0 : sh_a;
  assign base_b = frame_go ? '0 : sh_b;

  function automatic logic [31:0] pick(input logic [31:0] raw, input logic [5:0] sl,
                                       input logic [5:0] wl, input logic rj);
    logic [31:0] w;
    logic [5:0]  s;
    w = rj ? raw : (raw >> (sl - wl));
    s = 6'd32 - wl;
    return $unsigned($signed(w << s) >>> s);
  endfunction

  logic [31:0]        val_a, val_b, out_n;
  logic signed [32:0] mix_sum;
  assign val_a   = done_a ? pick(sh_a, slen_n, weff, right_just) : '0;
  assign val_b   = done_b ? pick(sh_b, slen_n, weff, right_just) : '0;
  assign mix_sum = $signed({val_a[31], val_a}) + $signed({val_b[31], val_b});
  assign out_n   = (src_sel == 2'd3) ? mix_sum[32:1] : val_a;

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) begin
      fs_q <= 1'b0; in_q <= 1'b0; seen_q <= 1'b0;
      lead_q <= '0; bit_q <= '0; slot_q <= '0;
      sh_a <= '0; sh_b <= '0; done_a <= 1'b0; done_b <= 1'b0;
      sample <= '0; sample_vld <= 1'b0;
    end else begin
      fs_q   <= fs_c;
      in_q   <= active;
      seen_q <= seen_q | frame_go;
      lead_q <= (&cur_lead) ? cur_lead : cur_lead + 1'b1;
      if (active) begin
        if (last_bit) begin
          bit_q  <= '0;
          slot_q <= (&cur_slot) ? cur_slot : cur_slot + 1'b1;
        end else begin
          bit_q  <= cur_bit + 1'b1;
          slot_q <= cur_slot;
        end
      end
      sh_a   <= hit_a ? {base_a[30:0], sd_c} : base_a;
      sh_b   <= hit_b ? {base_b[30:0], sd_c} : base_b;
      done_a <= (done_a & ~frame_go) | (hit_a & last_bit);
      done_b <= (done_b & ~frame_go) | (hit_b & last_bit);
      sample_vld <= frame_go & seen_q;
      if (frame_go & seen_q) sample <= out_n;
    end

  p_vld_pulse_r10: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  p_sign_ext_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    (sample_vld && src_sel != 2'd3) |->
      ((($signed(sample) >>> (weff - 6'd1)) == 32'sd0) ||
       (($signed(sample) >>> (weff - 6'd1)) == -32'sd1)));

  p_mute_r9: assert property (@(posedge bclk) disable iff (!rst_n)
    (sample_vld && src_sel != 2'd3 && !$past(done_a)) |-> (sample == 32'd0));

  p_bit_bound_r4: assert property (@(posedge bclk) disable iff (!rst_n)
    in_q |-> ({1'b0, bit_q} < slen_n));

endmodule

// File: tb/tdm_playback_rx_test.sv
module tdm_playback_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic fs_fall_start = 1'b0, cap_on_fall = 1'b0, right_just = 1'b0;
  logic [4:0] slot0_delay = '0;
  logic [1:0] slot_len_sel = '0, word_len_sel = '0, src_sel = '0;
  logic [3:0] left_slot = '0, right_slot = '0, addr_slot = '0;
  logic [31:0] sample;
  logic sample_vld;

  always #2 clk = ~clk;

  tdm_playback_rx uut (
    .bclk(clk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin),
    .fs_fall_start(fs_fall_start), .cap_on_fall(cap_on_fall),
    .slot0_delay(slot0_delay), .slot_len_sel(slot_len_sel),
    .word_len_sel(word_len_sel), .right_just(right_just), .src_sel(src_sel),
    .left_slot(left_slot), .right_slot(right_slot), .addr_slot(addr_slot),
    .sample(sample), .sample_vld(sample_vld));

  int n_run = 0, n_fail = 0;
  logic [31:0] expq [0:7];
  string tagq [0:7];
  int wr = 0, rd = 0;
  string cfg_s;

  function automatic longint word_of(logic [31:0] r, int sl, int wl, bit rj);
    int we = (wl < sl) ? wl : sl;
    longint raw = longint'(r) % (64'd1 << sl);
    longint v = rj ? raw % (64'd1 << we) : raw / (64'd1 << (sl - we));
    if (v >= (64'd1 << (we - 1))) v = v - (64'd1 << we);
    return v;
  endfunction

  // R11, R10, R5..R9: monitor compares each strobe against the expected queue
  always @(posedge clk) begin
    #3;
    if (rst_n && sample_vld) begin
      n_run++;
      if (rd >= wr) begin
        n_fail++;
        $display("FAIL R10 unexpected strobe: actual %h expected none (%s)", sample, cfg_s);
      end else begin
        if (sample !== expq[rd]) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (%s)", tagq[rd], sample, expq[rd], cfg_s);
        end
        rd++;
      end
    end
  end

  task automatic send_frame(int n, int off, int sl, bit pol, logic [31:0] sv [16]);
    for (int b = 0; b < n; b++) begin
      @(posedge clk); #1;
      fsync = (b < n / 2) ? ~pol : pol;
      if (b >= off && (b - off) / sl < 16)
        sdin = sv[(b - off) / sl][sl - 1 - ((b - off) % sl)];
      else
        sdin = 1'($urandom);
    end
  endtask

  task automatic run_cfg(int k);
    int offs [4] = '{0, 1, 3, 31};
    int lens [5] = '{64, 128, 256, 96, 192};
    int sl, wl, off, n, sa;
    logic [31:0] sv [16];
    // R1 frame polarity, R2 capture edge, R3 delay, R4 slot width swept here
    src_sel       = 2'(k % 4);
    fs_fall_start = 1'((k / 4) % 2);
    cap_on_fall   = 1'((k / 8) % 2);
    slot_len_sel  = 2'((k / 16) % 3);
    word_len_sel  = 2'((k / 48) % 4);
    right_just    = 1'((k / 3) % 2);
    off = offs[(k / 5) % 4];
    n   = lens[(k / 7) % 5];
    slot0_delay = 5'(off);
    left_slot  = 4'((k * 7) % 16);
    right_slot = 4'((k * 5 + 3) % 16);
    addr_slot  = 4'((k * 3) % 16);
    sl = (slot_len_sel == 0) ? 16 : (slot_len_sel == 1) ? 24 : 32;
    wl = (word_len_sel == 0) ? 16 : (word_len_sel == 1) ? 20 : (word_len_sel == 2) ? 24 : 32;
    cfg_s = $sformatf("R1 R2 R3 R4 k=%0d pol=%0d cap=%0d off=%0d slen=%0d wlen=%0d rj=%0d src=%0d n=%0d",
                      k, fs_fall_start, cap_on_fall, off, sl, wl, right_just, src_sel, n);
    fsync = fs_fall_start;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    n_run++;
    if (sample_vld !== 1'b0 || sample !== 32'd0) begin
      n_fail++;
      $display("FAIL R11 reset state: actual vld=%b data=%h expected vld=0 data=0", sample_vld, sample);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    wr = 0; rd = 0;
    sa = (src_sel == 0) ? addr_slot : (src_sel == 2) ? right_slot : left_slot;
    for (int f = 0; f < 4; f++) begin
      longint va, vb, e;
      bit oka, okb;
      foreach (sv[i]) sv[i] = $urandom;
      if (f < 3) begin
        oka = (off + (sa + 1) * sl) <= n;
        okb = (off + (right_slot + 1) * sl) <= n;
        va = oka ? word_of(sv[sa], sl, wl, right_just) : 0;
        vb = okb ? word_of(sv[right_slot], sl, wl, right_just) : 0;
        e = (src_sel == 3) ? ((va + vb) >>> 1) : va;
        expq[wr] = 32'(e);
        if (src_sel != 3 && !oka)      tagq[wr] = "R9 muted slot";
        else if (src_sel == 3)         tagq[wr] = (oka && okb) ? "R8 down-mix" : "R9 R8 down-mix with missing slot";
        else if (src_sel != 0)         tagq[wr] = "R7 left/right mono";
        else if (right_just)           tagq[wr] = "R6 right justified";
        else                           tagq[wr] = "R5 left justified";
        wr++;
      end
      send_frame(n, off, sl, fs_fall_start, sv);
    end
    repeat (4) @(posedge clk);
    #3;
    n_run++;
    if (rd != 3) begin
      n_fail++;
      $display("FAIL R10 strobe count: actual %0d expected 3 (%s)", rd, cfg_s);
    end
  endtask

  initial begin
    for (int k = 0; k < 192; k++) run_cfg(k);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule